// File: doc/BRIEF.md
# Lockable Watchdog Configuration Controller

This block holds a 16-bit chip-option word and runs the watchdog timer that the word configures. Software writes the word once after reset to pick a watchdog timeout length (or turn the watchdog off), the clock that advances the watchdog, a two-bit speed trim for the ring oscillator, and a force-on override for the crystal oscillator. Setting the freeze bit makes the whole word read-only until the next reset.

The watchdog advances on single-cycle ticks. A tick comes either from a prescaler that divides the system clock by `PRESCALE` (128 by default) or from a synchronised rising edge of the ring-oscillator tick input. When the count reaches the configured length, the block emits a one-cycle timeout pulse and sets a sticky fired flag. The block also drives the enables for the two oscillators. The oscillators themselves are outside the block. The clock-control disable bits arrive on input pins, and the configuration word can override them.

Top module: `wdcfg_top`

## Requirements
- R1: After reset the word reads 0x0000, the watchdog is off, the prescaler source is selected, the word is not frozen and `wd_fired` is 0.
- R2: Bits 5:4 set the timeout length in ticks. 00 turns the watchdog off and no timeout occurs. 01 gives 2^EXP_LO ticks, 10 gives 2^EXP_MID ticks and 11 gives 2^EXP_HI ticks (12, 14 and 16 by default).
- R3: When bit 3 is 0, the watchdog advances once per `PRESCALE` system clocks. When bit 3 is 1, it advances once per rising edge of `ring_tick` and ignores the prescaler.
- R4: `ring_en` is 1 whenever bit 3 is 1, whatever `ring_dis` is. When bit 3 is 0, `ring_en` is the inverse of `ring_dis`.
- R5: `xtal_en` is 1 whenever bit 6 is 1, whatever `osc_dis` is. When bit 6 is 0, `xtal_en` is the inverse of `osc_dis`.
- R6: Bits 8:7 appear unchanged on `ring_speed`.
- R7: Bits 15:12, 10:9 and 2:0 always read as 0, whatever value was written.
- R8: Once bit 11 reads 1, writes change no bit of the word, bit 11 included. A reset releases the freeze.
- R9: A `kick` pulse restarts the count from zero. An accepted write that changes bits 5:4 also restarts the count.
- R10: On the final tick of the timeout length, `wd_timeout` is high for exactly one cycle and the count starts again from zero.
- R11: `wd_fired` goes to 1 together with the first timeout and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 16 | Configuration word to write |
| rd_data | output | 16 | Current configuration word |
| osc_dis | input | 1 | Crystal oscillator disable bit from the clock-control register |
| ring_dis | input | 1 | Ring oscillator disable bit from the clock-control register |
| ring_tick | input | 1 | Asynchronous tick input from the ring oscillator |
| kick | input | 1 | Watchdog service pulse |
| xtal_en | output | 1 | Crystal oscillator run enable |
| ring_en | output | 1 | Ring oscillator run enable |
| ring_speed | output | 2 | Ring oscillator speed trim code |
| wd_timeout | output | 1 | One-cycle timeout request |
| wd_fired | output | 1 | Sticky flag: a timeout has occurred since reset |

## Verification
The bench counts ring-oscillator edges exactly. A timeout must appear on the sixteenth edge and not on the fifteenth, so an off-by-one terminal compare shows up at once. It checks that a frozen word rejects a write that would clear the freeze bit itself. A design that let that write through would unlock the word. It checks that a kick or a change of length restarts the count, so a design that ignored either would time out early. It also checks the two override outputs against their disable inputs, and that reserved bits written as ones read back as zero.

// File: rtl/wdcfg_pkg.sv
package wdcfg_pkg;

    typedef enum logic [1:0] {
        WD_OFF   = 2'b00,
        WD_SHORT = 2'b01,
        WD_MID   = 2'b10,
        WD_LONG  = 2'b11
    } wd_len_e;

    typedef struct packed {
        logic       frozen;
        logic [1:0] speed;
        logic       xtal_force;
        wd_len_e    len;
        logic       ring_src;
    } cfg_t;

    localparam int unsigned BIT_FROZEN = 11;
    localparam int unsigned BIT_SPD_HI = 8;
    localparam int unsigned BIT_SPD_LO = 7;
    localparam int unsigned BIT_XFORCE = 6;
    localparam int unsigned BIT_LEN_HI = 5;
    localparam int unsigned BIT_LEN_LO = 4;
    localparam int unsigned BIT_RSRC   = 3;

    localparam cfg_t CFG_RESET = '{frozen: 1'b0, speed: 2'b00, xtal_force: 1'b0,
                                   len: WD_OFF, ring_src: 1'b0};

    function automatic cfg_t cfg_from_word(input logic [15:0] w);
        cfg_t c;
        c.frozen     = w[BIT_FROZEN];
        c.speed      = w[BIT_SPD_HI:BIT_SPD_LO];
        c.xtal_force = w[BIT_XFORCE];
        c.len        = wd_len_e'(w[BIT_LEN_HI:BIT_LEN_LO]);
        c.ring_src   = w[BIT_RSRC];
        return c;
    endfunction

    function automatic logic [15:0] cfg_to_word(input cfg_t c);
        logic [15:0] w;
        w = '0;
        w[BIT_FROZEN]            = c.frozen;
        w[BIT_SPD_HI:BIT_SPD_LO] = c.speed;
        w[BIT_XFORCE]            = c.xtal_force;
        w[BIT_LEN_HI:BIT_LEN_LO] = c.len;
        w[BIT_RSRC]              = c.ring_src;
        return w;
    endfunction

endpackage

// File: rtl/wdcfg_reg.sv
module wdcfg_reg
    import wdcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output cfg_t        cfg,
    output logic        len_change
);
    cfg_t nxt;
    logic accept;

    always_comb begin
        nxt        = cfg_from_word(wr_data);
        accept     = wr_en && !cfg.frozen;
        len_change = accept && (nxt.len != cfg.len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (accept) begin
            cfg <= nxt;
        end
    end
endmodule

// File: rtl/wdcfg_ticks.sv
module wdcfg_ticks #(
    parameter int unsigned PRESCALE = 128,
    parameter int unsigned SYNC_N   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ring_src,
    input  logic ring_tick,
    output logic tick
);
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

    logic [PW-1:0]   pre_cnt;
    logic            pre_tick;
    logic [SYNC_N:0] sync_q;
    logic            ring_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
        end else if (pre_cnt == PLAST) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assign pre_tick = (pre_cnt == PLAST);

    generate
        for (genvar i = 0; i <= SYNC_N; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= ring_tick;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b0;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    assign ring_edge = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
    assign tick      = ring_src ? ring_edge : pre_tick;
endmodule

// File: rtl/wdcfg_counter.sv
module wdcfg_counter
    import wdcfg_pkg::*;
#(
    parameter int unsigned EXP_LO  = 12,
    parameter int unsigned EXP_MID = 14,
    parameter int unsigned EXP_HI  = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  wd_len_e len,
    input  logic    tick,
    input  logic    restart,
    output logic    timeout,
    output logic    fired
);
    localparam int unsigned CW = EXP_HI + 1;
    localparam logic [CW-1:0] LIM_LO  = CW'((32'd1 << EXP_LO)  - 32'd1);
    localparam logic [CW-1:0] LIM_MID = CW'((32'd1 << EXP_MID) - 32'd1);
    localparam logic [CW-1:0] LIM_HI  = CW'((32'd1 << EXP_HI)  - 32'd1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic          running;

    always_comb begin
        running = (len != WD_OFF);
        case (len)
            WD_SHORT: last = LIM_LO;
            WD_MID:   last = LIM_MID;
            WD_LONG:  last = LIM_HI;
            default:  last = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            timeout <= 1'b0;
            fired   <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (restart || !running) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == last) begin
                    cnt     <= '0;
                    timeout <= 1'b1;
                    fired   <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdcfg_top.sv
module wdcfg_top
    import wdcfg_pkg::*;
#(
    parameter int unsigned PRESCALE = 128,
    parameter int unsigned EXP_LO   = 12,
    parameter int unsigned EXP_MID  = 14,
    parameter int unsigned EXP_HI   = 16,
    parameter int unsigned SYNC_N   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        osc_dis,
    input  logic        ring_dis,
    input  logic        ring_tick,
    input  logic        kick,
    output logic        xtal_en,
    output logic        ring_en,
    output logic [1:0]  ring_speed,
    output logic        wd_timeout,
    output logic        wd_fired
);
    cfg_t cfg;
    logic len_change;
    logic tick;

    wdcfg_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cfg        (cfg),
        .len_change (len_change)
    );

    wdcfg_ticks #(.PRESCALE(PRESCALE), .SYNC_N(SYNC_N)) u_ticks (
        .clk       (clk),
        .rst       (rst),
        .ring_src  (cfg.ring_src),
        .ring_tick (ring_tick),
        .tick      (tick)
    );

    wdcfg_counter #(.EXP_LO(EXP_LO), .EXP_MID(EXP_MID), .EXP_HI(EXP_HI)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .len     (cfg.len),
        .tick    (tick),
        .restart (kick || len_change),
        .timeout (wd_timeout),
        .fired   (wd_fired)
    );

    assign rd_data    = cfg_to_word(cfg);
    assign xtal_en    = cfg.xtal_force | ~osc_dis;
    assign ring_en    = cfg.ring_src | ~ring_dis;
    assign ring_speed = cfg.speed;
endmodule

// File: rtl/wdcfg_checker.sv
module wdcfg_checker (
    input logic        clk,
    input logic        rst,
    input logic        kick,
    input logic [15:0] rd_data,
    input logic        xtal_en,
    input logic        ring_en,
    input logic        wd_timeout,
    input logic        wd_fired
);
    a_r8_frozen_stable: assert property (@(posedge clk) disable iff (rst)
        rd_data[11] |=> $stable(rd_data));

    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data & 16'hF607) == 16'h0000);

    a_r4_ring_override: assert property (@(posedge clk) disable iff (rst)
        rd_data[3] |-> ring_en);

    a_r5_xtal_override: assert property (@(posedge clk) disable iff (rst)
        rd_data[6] |-> xtal_en);

    a_r2_off_no_timeout: assert property (@(posedge clk) disable iff (rst)
        (rd_data[5:4] == 2'b00) |=> !wd_timeout);

    a_r9_kick_no_timeout: assert property (@(posedge clk) disable iff (rst)
        kick |=> !wd_timeout);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wd_timeout |=> !wd_timeout);

    a_r11_fired_sticky: assert property (@(posedge clk) disable iff (rst)
        wd_fired |=> wd_fired);

    a_r11_fired_with_pulse: assert property (@(posedge clk) disable iff (rst)
        wd_timeout |-> wd_fired);
endmodule

bind wdcfg_top wdcfg_checker u_chk (.*);

// File: tb/wdcfg_top_test.sv
module wdcfg_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        osc_dis = 1'b0;
    logic        ring_dis = 1'b0;
    logic        ring_tick = 1'b0;
    logic        kick = 1'b0;
    logic        xtal_en;
    logic        ring_en;
    logic [1:0]  ring_speed;
    logic        wd_timeout;
    logic        wd_fired;

    int total = 0;
    int bad = 0;
    int to_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdcfg_top #(.PRESCALE(4), .EXP_LO(4), .EXP_MID(5), .EXP_HI(6), .SYNC_N(2)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .osc_dis(osc_dis), .ring_dis(ring_dis), .ring_tick(ring_tick), .kick(kick),
        .xtal_en(xtal_en), .ring_en(ring_en), .ring_speed(ring_speed),
        .wd_timeout(wd_timeout), .wd_fired(wd_fired)
    );

    always @(negedge clk) if (!rst && wd_timeout) to_seen++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cycles(3);
        rst = 1'b0;
        to_seen = 0;
    endtask

    task automatic write(input logic [15:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic ring_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ring_tick = 1'b1;
            cycles(4);
            ring_tick = 1'b0;
            cycles(4);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 word", rd_data, 16'h0000);
        chk("R1 fired", wd_fired, 1'b0);
        cycles(100);
        chk("R1 off no timeout", to_seen, 0);
    endtask

    task automatic t_reserved();
        do_reset();
        write(16'hF607);
        chk("R7 reserved read zero", rd_data, 16'h0000);
    endtask

    task automatic t_speed();
        do_reset();
        for (int c = 0; c < 4; c++) begin
            write(16'(c << 7));
            chk("R6 speed code", ring_speed, c);
        end
    endtask

    task automatic t_osc();
        do_reset();
        osc_dis = 1'b1; ring_dis = 1'b1; @(negedge clk);
        chk("R5 xtal follows disable", xtal_en, 1'b0);
        chk("R4 ring follows disable", ring_en, 1'b0);
        osc_dis = 1'b0; ring_dis = 1'b0; @(negedge clk);
        chk("R5 xtal enabled", xtal_en, 1'b1);
        chk("R4 ring enabled", ring_en, 1'b1);
        osc_dis = 1'b1; ring_dis = 1'b1;
        write(16'h0048);
        chk("R5 force overrides disable", xtal_en, 1'b1);
        chk("R4 ring source overrides disable", ring_en, 1'b1);
        osc_dis = 1'b0; ring_dis = 1'b0;
    endtask

    task automatic t_lock();
        do_reset();
        write(16'h0958);
        chk("R8 locked word", rd_data, 16'h0958);
        write(16'h0000);
        chk("R8 write ignored incl lock", rd_data, 16'h0958);
        chk("R8 speed held", ring_speed, 2'b10);
        do_reset();
        write(16'h0180);
        chk("R8 reset releases", rd_data, 16'h0180);
    endtask

    task automatic t_ring_exact();
        do_reset();
        write(16'h0018);
        ring_pulses(15);
        chk("R2 no timeout at 15 ticks", to_seen, 0);
        ring_pulses(1);
        chk("R10 one pulse at 16 ticks", to_seen, 1);
        chk("R11 fired set", wd_fired, 1'b1);
        ring_pulses(15);
        chk("R10 restart from zero", to_seen, 1);
        ring_pulses(1);
        chk("R10 second period", to_seen, 2);
        cycles(200);
        chk("R3 prescaler ignored in ring mode", to_seen, 2);
        kick = 1'b1; @(negedge clk); kick = 1'b0;
        cycles(5);
        chk("R11 fired sticky", wd_fired, 1'b1);
        do_reset();
        chk("R11 cleared by reset", wd_fired, 1'b0);
    endtask

    task automatic t_kick();
        do_reset();
        write(16'h0018);
        ring_pulses(10);
        kick = 1'b1; @(negedge clk); kick = 1'b0;
        ring_pulses(10);
        chk("R9 kick restarts count", to_seen, 0);
        ring_pulses(6);
        chk("R9 timeout 16 after kick", to_seen, 1);
        do_reset();
        write(16'h0018);
        ring_pulses(10);
        write(16'h0028);
        ring_pulses(31);
        chk("R9 length change restarts", to_seen, 0);
        ring_pulses(1);
        chk("R2 mid length 32 ticks", to_seen, 1);
    endtask

    task automatic t_prescale(input logic [15:0] w, input int early, input int late, input string tag);
        do_reset();
        write(w);
        cycles(early);
        chk({tag, " none early"}, to_seen, 0);
        cycles(late - early);
        chk({tag, " one by window"}, to_seen, 1);
    endtask

    initial begin
        t_reset();
        t_reserved();
        t_speed();
        t_osc();
        t_lock();
        t_ring_exact();
        t_kick();
        t_prescale(16'h0010, 56, 70, "R3 R2 short prescaled");
        t_prescale(16'h0020, 120, 134, "R2 mid prescaled");
        t_prescale(16'h0030, 248, 262, "R2 long prescaled");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule